// File: doc/BRIEF.md
# Prioritized Loadable Up/Down Counter

This block is a small wrapping counter. It can clear, freeze, take a parallel value, or step up or down by one. A slow periodic enable paces it, so a fast system clock can drive a count that moves at a human-visible rate, for example once a second. Clearing does not wait for the enable. The other three actions happen only on a clock edge where the enable is high.

When several controls are active together, a fixed ranking decides which one wins: clear, then freeze, then parallel load, then step direction. A terminal-count flag marks the end of the range in the current direction. It marks the top value while counting up and zero while counting down. The flag is decoded from the registered count and the live direction input, so it follows a direction change at once.

Top module: `prio_step_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, `count` becomes 0 after that edge. This holds whatever the values of `tick`, `hold`, `load` and `up`.
- R2: With `rst` low and `tick` low at an edge, `count` keeps its value. `hold`, `load`, `up` and `par_in` have no effect on it.
- R3: With `rst` low, `tick` high and `hold` high at an edge, `count` keeps its value even when `load` is high or `up` has either value.
- R4: With `rst` and `hold` low, `tick` high and `load` high at an edge, `count` takes the value of `par_in`.
- R5: With `rst`, `hold` and `load` low, `tick` high and `up` = 1 at an edge, `count` goes up by one modulo 2^W, so 15 becomes 0 when W = 4.
- R6: With `rst`, `hold` and `load` low, `tick` high and `up` = 0 at an edge, `count` goes down by one modulo 2^W, so 0 becomes 15 when W = 4.
- R7: `tc` is 1 when `up` = 1 and `count` equals 2^W−1.
- R8: `tc` is 1 when `up` = 0 and `count` equals 0. In every other case `tc` is 0. A change on `up` shows on `tc` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous clear, active high, highest rank |
| tick | input | 1 | Periodic enable; hold, load and step act only when it is high |
| hold | input | 1 | Freeze the count (second rank) |
| load | input | 1 | Copy `par_in` into the count (third rank) |
| up | input | 1 | Step direction: 1 counts up, 0 counts down (lowest rank) |
| par_in | input | W | Parallel load value |
| count | output | W | Registered count |
| tc | output | 1 | Terminal-count flag |

## Verification
Every change to `count` passes through one register. A control word applied before a rising edge therefore shows its result on `count` right after that same edge. `tc` is combinational on top of that register and also depends on the `up` input, which is still applied at that moment. The driver changes inputs on the falling edge and queues the expected `{tc, count}` word at the same time. The monitor compares that word one time unit after the next rising edge, so each check lands exactly one cycle after its stimulus, and stimulus and sampling never share an edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Action chosen for the next clock edge, in decreasing rank.
    typedef enum logic [2:0] {
        ACT_CLEAR = 3'd0,
        ACT_KEEP  = 3'd1,
        ACT_LOAD  = 3'd2,
        ACT_INC   = 3'd3,
        ACT_DEC   = 3'd4
    } ctr_act_e;

endpackage

// File: rtl/ctr_arbiter.sv
module ctr_arbiter
    import ctr_pkg::*;
(
    input  logic     rst,
    input  logic     tick,
    input  logic     hold,
    input  logic     load,
    input  logic     up,
    output ctr_act_e act
);

    // Clear wins on any edge; the others need the enable tick.
    always_comb begin
        if (rst) begin
            act = ACT_CLEAR;
        end else if (!tick) begin
            act = ACT_KEEP;
        end else if (hold) begin
            act = ACT_KEEP;
        end else if (load) begin
            act = ACT_LOAD;
        end else if (up) begin
            act = ACT_INC;
        end else begin
            act = ACT_DEC;
        end
    end

endmodule

// File: rtl/ctr_stepper.sv
module ctr_stepper
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  ctr_act_e       act,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   par,
    output logic [W-1:0]   nxt
);

    localparam logic [W-1:0] ONE = W'(1);

    // Modulo-2^W arithmetic: the carry out is dropped on purpose.
    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = par;
            ACT_INC:   nxt = cur + ONE;
            ACT_DEC:   nxt = cur - ONE;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_tc_detect.sv
module ctr_tc_detect #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic         tc
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic at_top;
    logic at_zero;

    assign at_top  = (cur == TOP);
    assign at_zero = (cur == '0);
    assign tc      = up ? at_top : at_zero;

endmodule

// File: rtl/prio_step_counter.sv
module prio_step_counter
    import ctr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         hold,
    input  logic         load,
    input  logic         up,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] count,
    output logic         tc
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t   st_d;
    ctr_state_t   st_q;
    ctr_act_e     act;
    logic [W-1:0] step_nxt;

    ctr_arbiter u_arb (
        .rst  (rst),
        .tick (tick),
        .hold (hold),
        .load (load),
        .up   (up),
        .act  (act)
    );

    ctr_stepper #(.W(W)) u_step (
        .act (act),
        .cur (st_q.cnt),
        .par (par_in),
        .nxt (step_nxt)
    );

    ctr_tc_detect #(.W(W)) u_tc (
        .cur (st_q.cnt),
        .up  (up),
        .tc  (tc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = step_nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/prio_step_counter_chk.sv
module prio_step_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         hold,
    input logic         load,
    input logic         up,
    input logic [W-1:0] par_in,
    input logic [W-1:0] count,
    input logic         tc
);

    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = W'(1);

    // R1
    a_r1_clear_after_rst: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> count == '0);

    // R2
    a_r2_idle_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R3
    a_r3_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (tick && hold) |=> $stable(count));

    // R4
    a_r4_load_copies: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && load) |=> count == $past(par_in));

    // R5
    a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load && up) |=> count == $past(count) + ONE);

    // R6
    a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold && !load && !up) |=> count == $past(count) - ONE);

    // R7
    a_r7_tc_top: assert property (@(posedge clk) disable iff (rst)
        (up && count == TOP) |-> tc);

    // R8
    a_r8_tc_zero: assert property (@(posedge clk) disable iff (rst)
        (!up && count == '0) |-> tc);

    // R8
    a_r8_tc_quiet: assert property (@(posedge clk) disable iff (rst)
        (count != '0 && count != TOP) |-> !tc);

endmodule

bind prio_step_counter prio_step_counter_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hold   (hold),
    .load   (load),
    .up     (up),
    .par_in (par_in),
    .count  (count),
    .tc     (tc)
);

// File: tb/sim_prio_step_counter.sv
`timescale 1ns/1ps
module sim_prio_step_counter;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic         tick = 1'b0;
    logic         hold = 1'b0;
    logic         load = 1'b0;
    logic         up = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] count;
    logic         tc;

    always #2.5 clk = ~clk;

    prio_step_counter #(.W(W)) u0 (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .hold   (hold),
        .load   (load),
        .up     (up),
        .par_in (par_in),
        .count  (count),
        .tc     (tc)
    );

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t  sb_q[$];
    int     n_run  = 0;
    int     n_fail = 0;
    logic [3:0] model = '0;
    bit     done = 0;

    // Stimulus word: {par[3:0], up, hold, load, rst}; expected word: {tc, count[3:0]}.
    task automatic drive(input logic [7:0] vec, input logic tk, input string tag);
        item_t it;
        @(negedge clk);
        par_in = vec[7:4];
        up     = vec[3];
        hold   = vec[2];
        load   = vec[1];
        rst    = vec[0];
        tick   = tk;
        if (vec[0])            model = '0;
        else if (!tk || vec[2]) model = model;
        else if (vec[1])       model = vec[7:4];
        else if (vec[3])       model = model + 4'd1;
        else                   model = model - 4'd1;
        it.exp = {(vec[3] ? (model == 4'hF) : (model == 4'h0)), model};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_run++;
                if ({tc, count} !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, {tc, count}, it.exp);
                end
            end
        end
    end

    initial begin : stim
        drive(8'b0000_1001, 1'b0, "R1 reset state");
        drive(8'b0000_1001, 1'b1, "R1 reset with tick");
        drive(8'b0101_1010, 1'b1, "R4 load 5");
        for (int i = 0; i < 3; i++) drive(8'b0000_1000, 1'b1, "R5 count up");
        drive(8'b1110_1010, 1'b0, "R2 load ignored without tick");
        drive(8'b0000_0000, 1'b0, "R2 direction ignored without tick");
        drive(8'b1110_1010, 1'b1, "R4 load 14");
        drive(8'b0000_1000, 1'b1, "R7 up to 15 sets tc");
        drive(8'b0000_0000, 1'b0, "R8 tc follows down at 15");
        drive(8'b0000_1000, 1'b0, "R7 tc back when up again");
        drive(8'b0000_1000, 1'b1, "R5 wrap 15 to 0");
        drive(8'b0000_0000, 1'b0, "R8 tc at zero counting down");
        drive(8'b0000_0000, 1'b1, "R6 wrap 0 to 15");
        drive(8'b0000_0000, 1'b1, "R6 count down");
        drive(8'b0011_1110, 1'b1, "R3 hold beats load and up");
        drive(8'b0011_0100, 1'b1, "R3 hold beats down");
        drive(8'b0011_0111, 1'b0, "R1 reset beats hold without tick");
        drive(8'b0000_0000, 1'b1, "R6 down from 0");
        drive(8'b0010_0010, 1'b1, "R4 load beats direction");
        drive(8'b0000_0000, 1'b1, "R6 down to 1");
        drive(8'b0000_0000, 1'b1, "R8 down to 0 sets tc");
        drive(8'b0000_0100, 1'b0, "R2 no tick no change");
        drive(8'b1111_0011, 1'b1, "R1 reset beats load");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule